// File: doc/BRIEF.md
# Local Memory Direct Read Formatter

This block serves an operand decoder that has picked the "read straight from local shared memory" source. It takes one 32-bit control word. The low half of the word is a byte offset into a small byte-addressable scratch memory, and a 3-bit field above it picks how the addressed element is widened to 32 bits. The block fetches the element and returns the widened value one cycle later. It can return a byte or a halfword, zero- or sign-extended, or a full word.

A byte-wide write port loads the memory before reads begin. Reads use a simple request/valid scheme: each request returns its result exactly one cycle later, and a new request may be issued in every cycle. The memory is built as four byte-wide lanes that share one word index, so a block RAM can be inferred for each lane.

Top module: `lds_direct_reader`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `rd_valid` and `rd_err` are low and `rd_data` is zero.
- R2: Bits 15:0 of `ctrl_word` hold the byte offset and bits 18:16 hold the format code; bits 31:19 have no effect on the result.
- R3: Format code 0 returns the byte at the offset, zero-extended to 32 bits.
- R4: Format code 1 returns the little-endian halfword at the offset with offset bit 0 cleared (byte at the lower address in bits 7:0), zero-extended.
- R5: Format codes 2 and 3 both return the little-endian word at the offset with offset bits 1:0 cleared (lowest address in bits 7:0).
- R6: Format code 4 returns the addressed byte and code 5 the halfword (aligned as in R4), each sign-extended from its top bit to 32 bits.
- R7: Format codes 6 and 7 return zero with `rd_err` high in the result cycle; every legal code returns with `rd_err` low.
- R8: `rd_valid` is high in exactly the cycle after each cycle with `rd_req` high, so requests in consecutive cycles give results in consecutive cycles; otherwise `rd_valid` is low and `rd_data` is zero.
- R9: Read offsets and write addresses are taken modulo `MEM_BYTES` (a power of two, at least 8).
- R10: A write with `wr_en` high stores `wr_byte` at `wr_addr`, and reads issued in later cycles see the new byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 16 | Byte write address (wraps modulo memory size) |
| wr_byte | input | 8 | Byte to store |
| rd_req | input | 1 | Read request |
| ctrl_word | input | 32 | Offset in 15:0, format code in 18:16 |
| rd_valid | output | 1 | Result valid, one cycle after request |
| rd_data | output | 32 | Widened read result |
| rd_err | output | 1 | Illegal format code for this result |

## Verification
The bench builds the block with `MEM_BYTES` set to 1024. With that value, every byte can be preloaded and compared against a model in about a thousand cycles. Offsets between 1024 and 65535 still fit in the 16-bit field, so wrap-around on both reads and writes is exercised. Preloaded bytes above and below 0x80 let the sign-extending formats be checked with both signs.

// File: rtl/lds_dr_pkg.sv
`timescale 1ns/1ps
package lds_dr_pkg;
  localparam int CTRL_OFF_MSB = 15;
  localparam int CTRL_FMT_LSB = 16;
  localparam int CTRL_FMT_MSB = 18;

  typedef enum logic [2:0] {
    FMT_UBYTE    = 3'd0,
    FMT_UHALF    = 3'd1,
    FMT_WORD     = 3'd2,
    FMT_WORD_ALT = 3'd3,
    FMT_SBYTE    = 3'd4,
    FMT_SHALF    = 3'd5,
    FMT_BAD6     = 3'd6,
    FMT_BAD7     = 3'd7
  } fmt_e;
endpackage

// File: rtl/lds_dr_decode.sv
`timescale 1ns/1ps
module lds_dr_decode
  import lds_dr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic [31:0]       ctrl_word,
  output logic [ADDR_W-3:0] word_idx,
  output logic [1:0]        byte_sel,
  output fmt_e              fmt
);
  logic [15:0] offset;
  logic        unused_ctrl;

  assign offset      = ctrl_word[CTRL_OFF_MSB:0];
  assign word_idx    = offset[ADDR_W-1:2];
  assign byte_sel    = offset[1:0];
  assign fmt         = fmt_e'(ctrl_word[CTRL_FMT_MSB:CTRL_FMT_LSB]);
  assign unused_ctrl = ^ctrl_word;
endmodule

// File: rtl/lds_dr_bank.sv
`timescale 1ns/1ps
module lds_dr_bank #(
  parameter int DEPTH = 512,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [IDX_W-1:0] waddr,
  input  logic [7:0]       wdata,
  input  logic             re,
  input  logic [IDX_W-1:0] raddr,
  output logic [7:0]       q
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) q <= mem[raddr];
  end
endmodule

// File: rtl/lds_dr_extend.sv
`timescale 1ns/1ps
module lds_dr_extend
  import lds_dr_pkg::*;
(
  input  logic [31:0] lane_word,
  input  logic [1:0]  sel,
  input  fmt_e        fmt,
  output logic [31:0] data,
  output logic        err
);
  logic [7:0]  byte_v;
  logic [15:0] half_v;

  always_comb begin
    case (sel)
      2'd0:    byte_v = lane_word[7:0];
      2'd1:    byte_v = lane_word[15:8];
      2'd2:    byte_v = lane_word[23:16];
      default: byte_v = lane_word[31:24];
    endcase
    half_v = sel[1] ? lane_word[31:16] : lane_word[15:0];
  end

  always_comb begin
    err = 1'b0;
    case (fmt)
      FMT_UBYTE:              data = {24'd0, byte_v};
      FMT_UHALF:              data = {16'd0, half_v};
      FMT_WORD, FMT_WORD_ALT: data = lane_word;
      FMT_SBYTE:              data = {{24{byte_v[7]}}, byte_v};
      FMT_SHALF:              data = {{16{half_v[15]}}, half_v};
      default: begin
        data = 32'd0;
        err  = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/lds_direct_reader.sv
`timescale 1ns/1ps
module lds_direct_reader
  import lds_dr_pkg::*;
#(
  parameter int MEM_BYTES = 2048
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [7:0]  wr_byte,
  input  logic        rd_req,
  input  logic [31:0] ctrl_word,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        rd_err
);
  localparam int ADDR_W = $clog2(MEM_BYTES);
  localparam int WORDS  = MEM_BYTES / 4;
  localparam int IDX_W  = ADDR_W - 2;
  localparam int LANES  = 4;

  logic [IDX_W-1:0] rd_idx;
  logic [1:0]       rd_sel;
  fmt_e             rd_fmt;
  logic [1:0]       sel_q;
  fmt_e             fmt_q;
  logic [31:0]      lane_word;
  logic [31:0]      ext_data;
  logic             ext_err;
  logic             unused_waddr;

  assign unused_waddr = ^wr_addr;

  lds_dr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .ctrl_word (ctrl_word),
    .word_idx  (rd_idx),
    .byte_sel  (rd_sel),
    .fmt       (rd_fmt)
  );

  for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
    lds_dr_bank #(.DEPTH(WORDS)) u_bank (
      .clk   (clk),
      .we    (wr_en && (wr_addr[1:0] == 2'(ln))),
      .waddr (wr_addr[ADDR_W-1:2]),
      .wdata (wr_byte),
      .re    (rd_req),
      .raddr (rd_idx),
      .q     (lane_word[8*ln +: 8])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      sel_q    <= 2'd0;
      fmt_q    <= FMT_UBYTE;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) begin
        sel_q <= rd_sel;
        fmt_q <= rd_fmt;
      end
    end
  end

  lds_dr_extend u_ext (
    .lane_word (lane_word),
    .sel       (sel_q),
    .fmt       (fmt_q),
    .data      (ext_data),
    .err       (ext_err)
  );

  assign rd_data = rd_valid ? ext_data : 32'd0;
  assign rd_err  = rd_valid & ext_err;

  // R8
  valid_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  // R8
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rd_valid && rd_data == 32'd0));
  // R7
  illegal_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rd_err |-> (rd_valid && rd_data == 32'd0));
  // R7
  illegal_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ctrl_word[18:16] >= 3'd6) |=> rd_err);
  // R3
  ubyte_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ctrl_word[18:16] == 3'd0) |=> (rd_data[31:8] == 24'd0 && !rd_err));
  // R4
  uhalf_zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ctrl_word[18:16] == 3'd1) |=> (rd_data[31:16] == 16'd0));
  // R6
  sbyte_sign_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_req && ctrl_word[18:16] == 3'd4) |=>
      ($countones(rd_data[31:7]) == 0 || $countones(rd_data[31:7]) == 25));
endmodule

// File: tb/lds_direct_reader_tb.sv
`timescale 1ns/1ps
module lds_direct_reader_tb_top;
  localparam int MEMB = 1024;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0]  wr_byte = '0;
  logic        rd_req = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        rd_valid;
  logic [31:0] rd_data;
  logic        rd_err;

  int checks = 0;
  int errors = 0;
  logic [7:0] shadow [MEMB];

  always #4 clk = ~clk;

  lds_direct_reader #(.MEM_BYTES(MEMB)) dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_byte(wr_byte),
    .rd_req(rd_req), .ctrl_word(ctrl_word),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_err(rd_err)
  );

  task automatic check(input string req, input logic [33:0] got, input logic [33:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got valid/err/data=%h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [12:0] hi, input logic [2:0] fmt,
                                     input logic [15:0] off);
    return {hi, fmt, off};
  endfunction

  // model: {valid, err, data}
  function automatic logic [33:0] model(input logic [31:0] cw);
    int off = int'(cw[15:0]) % MEMB;
    int h = off & ~1;
    int w = off & ~3;
    logic [15:0] hv = {shadow[h+1], shadow[h]};
    logic [31:0] wv = {shadow[w+3], shadow[w+2], shadow[w+1], shadow[w]};
    case (cw[18:16])
      3'd0: return {2'b10, 24'd0, shadow[off]};
      3'd1: return {2'b10, 16'd0, hv};
      3'd2, 3'd3: return {2'b10, wv};
      3'd4: return {2'b10, {24{shadow[off][7]}}, shadow[off]};
      3'd5: return {2'b10, {16{hv[15]}}, hv};
      default: return {2'b11, 32'd0};
    endcase
  endfunction

  task automatic write_byte(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_byte = d;
    shadow[int'(a) % MEMB] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_one(input string req, input logic [31:0] cw);
    @(negedge clk);
    rd_req = 1'b1; ctrl_word = cw;
    @(negedge clk);
    rd_req = 1'b0;
    check(req, {rd_valid, rd_err, rd_data}, model(cw));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", {rd_valid, rd_err, rd_data}, 34'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", {rd_valid, rd_err, rd_data}, 34'd0);
  endtask

  task automatic t_preload;
    for (int a = 0; a < MEMB; a++) begin
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 16'(a); wr_byte = 8'((a * 37 + 11) & 255);
      shadow[a] = 8'((a * 37 + 11) & 255);
    end
    @(negedge clk);
    wr_en = 1'b0;
    read_one("R10 preload readback", mk(13'd0, 3'd2, 16'd100));
  endtask

  task automatic t_unsigned;
    read_one("R3 ubyte lane0", mk(13'd0, 3'd0, 16'd16));
    read_one("R3 ubyte lane3", mk(13'd0, 3'd0, 16'd23));
    read_one("R3 ubyte lane1", mk(13'd0, 3'd0, 16'd5));
    read_one("R4 uhalf aligned", mk(13'd0, 3'd1, 16'd40));
    read_one("R4 uhalf odd offset", mk(13'd0, 3'd1, 16'd43));
  endtask

  task automatic t_word;
    read_one("R5 word aligned", mk(13'd0, 3'd2, 16'd64));
    read_one("R5 word unaligned", mk(13'd0, 3'd2, 16'd71));
    read_one("R5 format3 as word", mk(13'd0, 3'd3, 16'd66));
  endtask

  task automatic t_signed;
    for (int o = 0; o < 8; o++) begin
      read_one("R6 sbyte", mk(13'd0, 3'd4, 16'(200 + o)));
      read_one("R6 shalf", mk(13'd0, 3'd5, 16'(300 + 2 * o + 1)));
    end
  endtask

  task automatic t_illegal;
    read_one("R7 format6", mk(13'd0, 3'd6, 16'd12));
    read_one("R7 format7", mk(13'd0, 3'd7, 16'd13));
    read_one("R7 legal after illegal", mk(13'd0, 3'd0, 16'd12));
  endtask

  task automatic t_back_to_back;
    logic [31:0] cws [4];
    cws[0] = mk(13'd0, 3'd0, 16'd3);
    cws[1] = mk(13'd0, 3'd7, 16'd9);
    cws[2] = mk(13'd0, 3'd5, 16'd510);
    cws[3] = mk(13'd0, 3'd2, 16'd1020);
    @(negedge clk);
    rd_req = 1'b1; ctrl_word = cws[0];
    for (int i = 1; i < 4; i++) begin
      @(negedge clk);
      check("R8 back-to-back", {rd_valid, rd_err, rd_data}, model(cws[i-1]));
      ctrl_word = cws[i];
    end
    @(negedge clk);
    rd_req = 1'b0;
    check("R8 back-to-back last", {rd_valid, rd_err, rd_data}, model(cws[3]));
    @(negedge clk);
    check("R8 idle after burst", {rd_valid, rd_err, rd_data}, 34'd0);
  endtask

  task automatic t_ctrl_fields;
    read_one("R2 high bits ignored word", mk(13'h1FFF, 3'd2, 16'd88));
    read_one("R2 high bits ignored sbyte", mk(13'h0AAA, 3'd4, 16'd91));
  endtask

  task automatic t_wrap;
    read_one("R9 read wrap byte", mk(13'd0, 3'd0, 16'(MEMB + 5)));
    read_one("R9 read wrap top", mk(13'd0, 3'd2, 16'hFFFF));
    write_byte(16'(MEMB + 8), 8'h80);
    read_one("R9 R10 write wrap", mk(13'd0, 3'd4, 16'd8));
    write_byte(16'd9, 8'hC3);
    read_one("R10 overwrite half", mk(13'd0, 3'd5, 16'd8));
  endtask

  initial begin
    #(8 * 20000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_preload();
    t_unsigned();
    t_word();
    t_signed();
    t_illegal();
    t_back_to_back();
    t_ctrl_fields();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule